// File: doc/BRIEF.md
# Reset-Cause and Clock-Security Status Register

This block is an 8-bit register on a simple bus. It records why the last reset happened and reports clock-security events. Hardware strobes come from the low-voltage detector, the watchdog, the external reset pin and the clock monitor. The block keeps them as sticky flags, and software reads and clears those flags through the bus port.

Two option-level inputs switch the low-voltage and clock-security features on or off. The block drives a level interrupt request and a safe-oscillator select. Both follow the clock-disturbance flag. The interrupt request is also gated by a software enable.

The two reset flags follow different clear rules. A low-voltage reset wipes the watchdog flag. The low-voltage flag stays set through later external or watchdog resets until software clears it. Together the two flags tell boot code which event caused the reset:

| Reset source | Low-voltage flag | Watchdog flag |
|---|---|---|
| External pin | 0 | 0 |
| Watchdog | 0 | 1 |
| Low voltage | 1 | 0 |

The disturbance flag clears only when the register is read after the main oscillator has recovered.

Top module: `rcs_status`

## Requirements
- R1: `rdata_o` always shows the register contents. The fields are: bit 4 low-voltage flag, bit 2 interrupt enable, bit 1 disturbance flag, bit 0 watchdog flag. Bits 7, 6, 5 and 3 always read 0.
- R2: A cycle with `lvd_rst_i`=1 and `lvd_en_i`=1 sets the low-voltage flag. While `lvd_en_i`=0 the flag is held at 0.
- R3: A cycle with `wdg_rst_i`=1 sets the watchdog flag. A cycle with `lvd_rst_i`=1 clears it, and this clear wins over a watchdog strobe in the same cycle.
- R4: A bus write is a cycle with `sel_i`=1 and `we_i`=1. A write with `wdata_i[4]`=0 clears the low-voltage flag. A write with `wdata_i[0]`=0 clears the watchdog flag. Writing 1 to either bit has no effect. A hardware set in the same cycle wins over the software clear.
- R5: Only `rst_ni` clears every bit of the register. The low-voltage and watchdog flags hold their values through external and watchdog reset strobes.
- R6: With `css_en_i`=1, a cycle with `clk_fail_i`=1 sets the disturbance flag. A bus read (`sel_i`=1, `we_i`=0) clears the flag only if `osc_ok_i`=1 in the same cycle. A set in the same cycle wins over this clear.
- R7: While `css_en_i`=0, the disturbance flag reads 0 and is cleared. In that state `css_irq_o` stays 0 whatever the enable bit holds.
- R8: The interrupt enable takes `wdata_i[2]` on every bus write. Any reset strobe (`ext_rst_i`, `wdg_rst_i` or `lvd_rst_i`) clears it, and the strobe wins over a write in the same cycle.
- R9: `css_irq_o` equals enable AND disturbance flag AND `css_en_i`. `safe_osc_o` equals the disturbance flag as it reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| lvd_en_i | input | 1 | Low-voltage feature enabled by option |
| css_en_i | input | 1 | Clock-security feature enabled by option |
| lvd_rst_i | input | 1 | Low-voltage reset strobe |
| wdg_rst_i | input | 1 | Watchdog reset strobe |
| ext_rst_i | input | 1 | External pin reset strobe |
| clk_fail_i | input | 1 | Main-clock disturbance strobe |
| osc_ok_i | input | 1 | Main oscillator has recovered (level) |
| sel_i | input | 1 | Bus access to this register |
| we_i | input | 1 | Bus access is a write |
| wdata_i | input | 8 | Bus write data |
| rdata_o | output | 8 | Register read data |
| css_irq_o | output | 1 | Clock-security interrupt request (level) |
| safe_osc_o | output | 1 | Select the safe oscillator |

## Verification
The bench makes two strobes or a strobe and a bus access fall in the same cycle, because that is where a design with the wrong priority gives itself away.

- **Watchdog and low-voltage strobes together.** If the watchdog strobe won, boot code would see the low-voltage and watchdog flags both set.
- **Flag clear with a hardware set in the same cycle.** If the software clear won, a reset cause recorded in that cycle would be lost.
- **Read while the oscillator is still down.** If the read cleared the flag anyway, the safe oscillator would be released too early.
- **Write of 1 to the flag bits.** If the write took effect, software could forge a reset cause.
- **Low-voltage flag through later resets.** An external or watchdog reset must not erase the low-voltage flag.
- **Feature-disable inputs toggling at random.** When the clock-security feature is off, the interrupt must not fire from a stale enable bit.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
  localparam int unsigned REG_W   = 8;
  localparam int unsigned BIT_LVD = 4;
  localparam int unsigned BIT_IE  = 2;
  localparam int unsigned BIT_DET = 1;
  localparam int unsigned BIT_WDG = 0;
endpackage

// File: rtl/rcs_reset_flags.sv
module rcs_reset_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvd_en_i,
  input  logic lvd_rst_i,
  input  logic wdg_rst_i,
  input  logic wr_i,
  input  logic wr_lvd_bit_i,
  input  logic wr_wdg_bit_i,
  output logic lvd_flag_o,
  output logic wdg_flag_o
);
  logic lvd_q, lvd_d, wdg_q, wdg_d;

  always_comb begin
    lvd_d = lvd_q;
    if (!lvd_en_i)                lvd_d = 1'b0;
    else if (lvd_rst_i)           lvd_d = 1'b1;
    else if (wr_i && !wr_lvd_bit_i) lvd_d = 1'b0;
  end

  // low-voltage reset dominates watchdog set
  always_comb begin
    wdg_d = wdg_q;
    if (lvd_rst_i)                wdg_d = 1'b0;
    else if (wdg_rst_i)           wdg_d = 1'b1;
    else if (wr_i && !wr_wdg_bit_i) wdg_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvd_q <= 1'b0;
      wdg_q <= 1'b0;
    end else begin
      lvd_q <= lvd_d;
      wdg_q <= wdg_d;
    end
  end

  assign lvd_flag_o = lvd_q;
  assign wdg_flag_o = wdg_q;
endmodule

// File: rtl/rcs_clk_sec.sv
module rcs_clk_sec (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic css_en_i,
  input  logic clk_fail_i,
  input  logic osc_ok_i,
  input  logic any_rst_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wr_ie_bit_i,
  output logic det_o,
  output logic ie_o,
  output logic irq_o
);
  logic det_q, det_d, ie_q, ie_d;

  always_comb begin
    det_d = det_q;
    if (!css_en_i)              det_d = 1'b0;
    else if (clk_fail_i)        det_d = 1'b1;
    else if (rd_i && osc_ok_i)  det_d = 1'b0;
  end

  always_comb begin
    ie_d = ie_q;
    if (any_rst_i) ie_d = 1'b0;
    else if (wr_i) ie_d = wr_ie_bit_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      det_q <= 1'b0;
      ie_q  <= 1'b0;
    end else begin
      det_q <= det_d;
      ie_q  <= ie_d;
    end
  end

  // mask at once when the feature is switched off
  assign det_o = det_q & css_en_i;
  assign ie_o  = ie_q;
  assign irq_o = ie_q & det_o;
endmodule

// File: rtl/rcs_status.sv
module rcs_status
  import rcs_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lvd_en_i,
  input  logic             css_en_i,
  input  logic             lvd_rst_i,
  input  logic             wdg_rst_i,
  input  logic             ext_rst_i,
  input  logic             clk_fail_i,
  input  logic             osc_ok_i,
  input  logic             sel_i,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output logic             css_irq_o,
  output logic             safe_osc_o
);
  logic rd, wr, any_rst;
  logic lvd_flag, wdg_flag, det, ie;

  assign rd      = sel_i & ~we_i;
  assign wr      = sel_i & we_i;
  assign any_rst = ext_rst_i | wdg_rst_i | lvd_rst_i;

  rcs_reset_flags u_flags (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .lvd_en_i     (lvd_en_i),
    .lvd_rst_i    (lvd_rst_i),
    .wdg_rst_i    (wdg_rst_i),
    .wr_i         (wr),
    .wr_lvd_bit_i (wdata_i[BIT_LVD]),
    .wr_wdg_bit_i (wdata_i[BIT_WDG]),
    .lvd_flag_o   (lvd_flag),
    .wdg_flag_o   (wdg_flag)
  );

  rcs_clk_sec u_css (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .css_en_i    (css_en_i),
    .clk_fail_i  (clk_fail_i),
    .osc_ok_i    (osc_ok_i),
    .any_rst_i   (any_rst),
    .rd_i        (rd),
    .wr_i        (wr),
    .wr_ie_bit_i (wdata_i[BIT_IE]),
    .det_o       (det),
    .ie_o        (ie),
    .irq_o       (css_irq_o)
  );

  always_comb begin
    rdata_o          = '0;
    rdata_o[BIT_LVD] = lvd_flag;
    rdata_o[BIT_IE]  = ie;
    rdata_o[BIT_DET] = det;
    rdata_o[BIT_WDG] = wdg_flag;
  end

  assign safe_osc_o = det;
endmodule

// File: rtl/rcs_checker.sv
module rcs_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       lvd_en_i,
  input logic       css_en_i,
  input logic       lvd_rst_i,
  input logic       wdg_rst_i,
  input logic       clk_fail_i,
  input logic       osc_ok_i,
  input logic       sel_i,
  input logic       we_i,
  input logic [7:0] rdata_o,
  input logic       css_irq_o
);
  assert_reserved_zero_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o[7:5] == 3'b000) && !rdata_o[3]);

  assert_lvd_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvd_rst_i && lvd_en_i) ##1 lvd_en_i |-> rdata_o[4]);

  assert_wdg_wiped_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvd_rst_i |=> !rdata_o[0]);

  assert_wdg_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wdg_rst_i && !lvd_rst_i) |=> rdata_o[0]);

  assert_det_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (css_en_i && clk_fail_i) ##1 css_en_i |-> rdata_o[1]);

  assert_det_read_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && !we_i && osc_ok_i && !clk_fail_i) |=> !rdata_o[1]);

  assert_det_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o[1] && css_en_i && !(sel_i && !we_i && osc_ok_i)) ##1 css_en_i |-> rdata_o[1]);

  assert_irq_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !css_en_i |-> !css_irq_o);
endmodule

bind rcs_status rcs_checker u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .lvd_en_i   (lvd_en_i),
  .css_en_i   (css_en_i),
  .lvd_rst_i  (lvd_rst_i),
  .wdg_rst_i  (wdg_rst_i),
  .clk_fail_i (clk_fail_i),
  .osc_ok_i   (osc_ok_i),
  .sel_i      (sel_i),
  .we_i       (we_i),
  .rdata_o    (rdata_o),
  .css_irq_o  (css_irq_o)
);

// File: tb/tb_rcs_status.sv
module tb_rcs_status;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       lvd_en_i = 1'b1, css_en_i = 1'b1;
  logic       lvd_rst_i = 1'b0, wdg_rst_i = 1'b0, ext_rst_i = 1'b0;
  logic       clk_fail_i = 1'b0, osc_ok_i = 1'b1;
  logic       sel_i = 1'b0, we_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       css_irq_o, safe_osc_o;

  int total = 0;
  int bad = 0;
  logic m_lvd = 0, m_wdg = 0, m_det = 0, m_ie = 0;

  always #10 clk_i = ~clk_i;

  rcs_status dut (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd();
    logic [7:0] v = '0;
    v[4] = m_lvd;
    v[2] = m_ie;
    v[1] = m_det & css_en_i;
    v[0] = m_wdg;
    return v;
  endfunction

  // all fields, checked at the negedge
  task automatic check_all();
    logic [7:0] e;
    e = exp_rd();
    chk("R1 reserved", {rdata_o[7:5], rdata_o[3]}, 8'h0);
    chk("R2 lvd flag", rdata_o[4], e[4]);
    chk("R3 wdg flag", rdata_o[0], e[0]);
    chk("R6 det flag", rdata_o[1], e[1]);
    chk("R8 enable", rdata_o[2], e[2]);
    chk("R9 irq", css_irq_o, e[2] & e[1] & css_en_i);
    chk("R9 safe osc", safe_osc_o, e[1]);
  endtask

  // model update from requirements R2..R8
  task automatic model_edge();
    logic rd, wr;
    rd = sel_i & ~we_i;
    wr = sel_i & we_i;
    if (!lvd_en_i) m_lvd = 0;
    else if (lvd_rst_i) m_lvd = 1;
    else if (wr && !wdata_i[4]) m_lvd = 0;
    if (lvd_rst_i) m_wdg = 0;
    else if (wdg_rst_i) m_wdg = 1;
    else if (wr && !wdata_i[0]) m_wdg = 0;
    if (!css_en_i) m_det = 0;
    else if (clk_fail_i) m_det = 1;
    else if (rd && osc_ok_i) m_det = 0;
    if (lvd_rst_i | wdg_rst_i | ext_rst_i) m_ie = 0;
    else if (wr) m_ie = wdata_i[2];
  endtask

  task automatic step(input logic le, ce, lr, wr_, er, cf, ok, s, w, input logic [7:0] d);
    lvd_en_i = le; css_en_i = ce; lvd_rst_i = lr; wdg_rst_i = wr_; ext_rst_i = er;
    clk_fail_i = cf; osc_ok_i = ok; sel_i = s; we_i = w; wdata_i = d;
    @(posedge clk_i);
    model_edge();
    @(negedge clk_i);
    check_all();
  endtask

  initial begin
    #4_000_000;
    bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk_i);
    chk("R5 reset value", rdata_o, 8'h00);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_all();
    // R3: both strobes together, lvd wins
    step(1,1, 1,1,0, 0,1, 0,0, 8'h00);
    chk("R3 lvd beats wdg", rdata_o[0], 1'b0);
    // R5: lvd flag survives wdg and ext resets
    step(1,1, 0,1,0, 0,1, 0,0, 8'h00);
    step(1,1, 0,0,1, 0,1, 0,0, 8'h00);
    chk("R5 lvd kept", rdata_o[4], 1'b1);
    // R4: write 1 no effect, write 0 with same-cycle set keeps flag
    step(1,1, 0,0,0, 0,1, 1,1, 8'hFF);
    chk("R4 write ones", rdata_o & 8'h11, 8'h11);
    step(1,1, 0,1,0, 0,1, 1,1, 8'h00);
    chk("R4 set beats clear", rdata_o[0], 1'b1);
    // R6: read with oscillator down keeps flag
    step(1,1, 0,0,0, 1,0, 0,0, 8'h00);
    step(1,1, 0,0,0, 0,0, 1,0, 8'h00);
    chk("R6 read osc down", rdata_o[1], 1'b1);
    step(1,1, 0,0,0, 0,0, 1,1, 8'h04);
    chk("R9 irq up", css_irq_o, 1'b1);
    step(1,0, 0,0,0, 0,0, 0,0, 8'h00);
    chk("R7 irq masked", css_irq_o, 1'b0);
    step(1,1, 0,0,0, 0,1, 1,0, 8'h00);
    chk("R6 read clears", rdata_o[1], 1'b0);
    // R2: lvd disabled ignores strobe
    step(0,1, 1,0,0, 0,1, 0,0, 8'h00);
    chk("R2 lvd disabled", rdata_o[4], 1'b0);
    // random phase
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 8) != 0, ($urandom % 8) != 0,
           ($urandom % 10) == 0, ($urandom % 8) == 0, ($urandom % 8) == 0,
           ($urandom % 6) == 0, ($urandom % 2) == 0,
           ($urandom % 2) == 0, ($urandom % 2) == 0, 8'($urandom));
      if (i == 1500) begin
        rst_ni = 1'b0;
        m_lvd = 0; m_wdg = 0; m_det = 0; m_ie = 0;
        @(negedge clk_i);
        chk("R5 power-on clear", rdata_o, 8'h00);
        rst_ni = 1'b1;
      end
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule